// File: doc/BRIEF.md
# Cascaded FIFO Ring Token Controller

This block is the control logic for one device in a ring of FIFO devices chained to form one deeper FIFO. Each device's ring output feeds the next device's ring input, and the last device feeds the first. Two ownership tokens travel around the ring on that one signal. The write token says which device may accept writes. The read token says which device may deliver reads. A device passes a token on with a one-cycle low pulse when it writes, or reads, its last physical location.

While reset is held, the block samples its ring input to choose the mode. A low input selects standalone operation. A high input, which is the idle level of a ring, selects ring operation. In ring operation the device whose first-device input is low starts with both tokens. All other devices start idle. The block drives the write and read addresses and enables for an external memory. It also produces local full, empty and half flags. Composite flags are formed outside the block by ORing the flags of all devices. Standalone mode also offers a retransmit that rewinds the read side.

Top module: `fifoRingCtrl`

## Requirements
- R1: When reset is released, both addresses are 0, emptyN is 0, fullN is 1, halfN is 1 and expOutN is 1. In ring mode a device with firstLoadN low holds both tokens (qOe is 1). A device with firstLoadN high holds neither token (qOe is 0, and wrEn stays 0 when wrReq is 1).
- R2: The mode is captured while rstN is low: expInN high gives ring mode, and expInN low gives standalone mode. In standalone mode both operations are always owned, qOe is 1, and expOutN stays 1.
- R3: wrEn is 1 exactly when wrReq is 1, the write token is held, the device is not full and no retransmit is active. fullN goes low when the device holds DEPTH words, and a write attempted while full changes nothing.
- R4: rdEn is 1 exactly when rdReq is 1, the read token is held, the device is not empty and no retransmit is active. emptyN goes low when the device holds 0 words, and a read attempted while empty changes nothing.
- R5: In ring mode, an accepted write at address DEPTH-1 drives expOutN low for exactly the following cycle and releases the write token. Later writes are refused even when the device is not full.
- R6: In ring mode, an accepted read at address DEPTH-1 drives expOutN low for exactly the following cycle and releases the read token. qOe then goes to 0.
- R7: In ring mode, each cycle with expInN low grants the write token if it is not held, or else grants the read token if it is not held. The test uses the token state from before the edge, so a pulse that arrives in the cycle the write token leaves grants the read token. A granted token is usable from the next cycle.
- R8: Each accepted write or read advances its address by one, wrapping from DEPTH-1 to 0. A write and a read in the same cycle leave the word count unchanged.
- R9: In standalone mode halfN is 0 exactly when the device holds more than DEPTH/2 words. In ring mode halfN stays 1.
- R10: In standalone mode, a cycle with rtN low sets rdAddr to 0. It sets the word count to the number of words written since reset, which is at most DEPTH. It also blocks any write or read in that cycle. In ring mode rtN has no effect.
- R11: qOe is 1 exactly when the device owns the read side: always in standalone mode, and while the read token is held in ring mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low master reset; the mode is sampled while it is low |
| firstLoadN | input | 1 | Low marks the device that owns both tokens after reset |
| expInN | input | 1 | Ring input; one cycle low per received token |
| expOutN | output | 1 | Ring output; one cycle low per token passed on |
| wrReq | input | 1 | Local write request |
| rdReq | input | 1 | Local read request |
| rtN | input | 1 | Active-low retransmit, standalone mode only |
| wrEn | output | 1 | Write strobe to the memory array |
| rdEn | output | 1 | Read strobe to the memory array |
| wrAddr | output | $clog2(DEPTH) | Write address |
| rdAddr | output | $clog2(DEPTH) | Read address |
| fullN | output | 1 | Low when the device holds DEPTH words |
| emptyN | output | 1 | Low when the device holds no words |
| halfN | output | 1 | Low when more than DEPTH/2 words are held (standalone mode) |
| qOe | output | 1 | Data output enable; high while the read side is owned |

## Verification
The hard case is an incoming ring pulse that lands in the same cycle as this device giving away its write token with a write to the last address. The bench sets this up by filling the device to the last write address while it holds only the write token. It then asserts wrReq and lowers expInN in the same cycle. After that edge, expOutN must be low, qOe must have risen because the read token was granted, and a further write must be refused. These results show that the grant decision used the token state from before the edge and did not lose either token.

// File: rtl/fifoRingPkg.sv
package fifoRingPkg;

  // strobes from the control to the pointer datapath
  typedef struct packed {
    logic doWr;
    logic doRd;
    logic doRetx;
  } ringStrobeT;

  // occupancy and position status from the datapath
  typedef struct packed {
    logic full;
    logic empty;
    logic half;
    logic lastWr;
    logic lastRd;
  } ringStatusT;

endpackage

// File: rtl/fifoRingDatapath.sv
module fifoRingDatapath
  import fifoRingPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ringStrobeT               strb,
  output ringStatusT               stat,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALFCNT = CW'(DEPTH / 2);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] wordCnt;
  logic          wrapped;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      wordCnt <= '0;
      wrapped <= 1'b0;
    end else if (strb.doRetx) begin
      rdPtr   <= '0;
      wordCnt <= wrapped ? FULLCNT : CW'(wrPtr);
    end else begin
      if (strb.doWr) begin
        wrPtr <= bump(wrPtr);
        if (wrPtr == LAST) wrapped <= 1'b1;
      end
      if (strb.doRd) rdPtr <= bump(rdPtr);
      case ({strb.doWr, strb.doRd})
        2'b10:   wordCnt <= wordCnt + CW'(1);
        2'b01:   wordCnt <= wordCnt - CW'(1);
        default: wordCnt <= wordCnt;
      endcase
    end
  end

  always_comb begin
    stat.full   = (wordCnt == FULLCNT);
    stat.empty  = (wordCnt == '0);
    stat.half   = (wordCnt > HALFCNT);
    stat.lastWr = (wrPtr == LAST);
    stat.lastRd = (rdPtr == LAST);
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

endmodule

// File: rtl/fifoRingControl.sv
module fifoRingControl
  import fifoRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       firstLoadN,
  input  logic       expInN,
  input  logic       wrReq,
  input  logic       rdReq,
  input  logic       rtN,
  input  ringStatusT stat,
  output ringStrobeT strb,
  output logic       expOutN,
  output logic       fullN,
  output logic       emptyN,
  output logic       halfN,
  output logic       qOe,
  output logic       depthMode
);
  logic wrTok, rdTok;
  logic wrOwn, rdOwn;
  logic passWr, passRd, inPulse;
  logic wrTokNxt, rdTokNxt;

  always_comb begin
    wrOwn       = !depthMode || wrTok;
    rdOwn       = !depthMode || rdTok;
    strb.doRetx = rstN && !depthMode && !rtN;
    strb.doWr   = rstN && wrReq && wrOwn && !stat.full  && !strb.doRetx;
    strb.doRd   = rstN && rdReq && rdOwn && !stat.empty && !strb.doRetx;
    passWr      = depthMode && strb.doWr && stat.lastWr;
    passRd      = depthMode && strb.doRd && stat.lastRd;
    inPulse     = depthMode && !expInN;

    // a received pulse fills the write slot first, then the read slot
    wrTokNxt = wrTok;
    rdTokNxt = rdTok;
    if (passWr) wrTokNxt = 1'b0;
    if (passRd) rdTokNxt = 1'b0;
    if (inPulse && !wrTok)               wrTokNxt = 1'b1;
    else if (inPulse && wrTok && !rdTok) rdTokNxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthMode <= expInN;
      wrTok     <= !firstLoadN;
      rdTok     <= !firstLoadN;
      expOutN   <= 1'b1;
    end else begin
      wrTok   <= wrTokNxt;
      rdTok   <= rdTokNxt;
      expOutN <= !(passWr || passRd);
    end
  end

  assign fullN  = !stat.full;
  assign emptyN = !stat.empty;
  assign halfN  = !(stat.half && !depthMode);
  assign qOe    = rdOwn;

endmodule

// File: rtl/fifoRingCtrl.sv
module fifoRingCtrl
  import fifoRingPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     firstLoadN,
  input  logic                     expInN,
  output logic                     expOutN,
  input  logic                     wrReq,
  input  logic                     rdReq,
  input  logic                     rtN,
  output logic                     wrEn,
  output logic                     rdEn,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic                     fullN,
  output logic                     emptyN,
  output logic                     halfN,
  output logic                     qOe
);
  ringStrobeT strb;
  ringStatusT stat;
  logic       depthMode;

  fifoRingControl u_ctrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN), .expInN(expInN),
    .wrReq(wrReq), .rdReq(rdReq), .rtN(rtN), .stat(stat), .strb(strb),
    .expOutN(expOutN), .fullN(fullN), .emptyN(emptyN), .halfN(halfN),
    .qOe(qOe), .depthMode(depthMode)
  );

  fifoRingDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  assign wrEn = strb.doWr;
  assign rdEn = strb.doRd;

endmodule

// File: rtl/fifoRingCheck.sv
module fifoRingCheck #(
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     expOutN,
  input logic                     rtN,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [$clog2(DEPTH)-1:0] wrAddr,
  input logic [$clog2(DEPTH)-1:0] rdAddr,
  input logic                     fullN,
  input logic                     emptyN,
  input logic                     halfN,
  input logic                     qOe,
  input logic                     depthMode
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> fullN);

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> emptyN);

  // R5 and R6: a ring pulse only follows a last-location access in ring mode
  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    !expOutN |-> depthMode &&
      $past((wrEn && wrAddr == LAST) || (rdEn && rdAddr == LAST)));

  a_r2_standalone_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !depthMode |-> expOutN && qOe);

  a_r9_half_off: assert property (@(posedge clk) disable iff (!rstN)
    depthMode |-> halfN);

  a_r10_retx_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (depthMode && !rtN && !rdEn) |=> $stable(rdAddr));

  a_r11_read_owned: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> qOe);

  a_r8_wr_advance: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> wrAddr == (($past(wrAddr) == LAST) ? '0 : $past(wrAddr) + AW'(1)));

endmodule

bind fifoRingCtrl fifoRingCheck #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .expOutN(expOutN), .rtN(rtN),
  .wrEn(wrEn), .rdEn(rdEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
  .fullN(fullN), .emptyN(emptyN), .halfN(halfN), .qOe(qOe),
  .depthMode(depthMode)
);

// File: tb/test_fifoRingCtrl.sv
module test_fifoRingCtrl;
  localparam int DEPTH = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, firstLoadN = 1'b0, expInN = 1'b0;
  logic wrReq = 1'b0, rdReq = 1'b0, rtN = 1'b1;
  logic idleXi = 1'b0;
  logic expOutN, wrEn, rdEn, fullN, emptyN, halfN, qOe;
  logic [AW-1:0] wrAddr, rdAddr;

  fifoRingCtrl #(.DEPTH(DEPTH)) i_fifoRingCtrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN), .expInN(expInN),
    .expOutN(expOutN), .wrReq(wrReq), .rdReq(rdReq), .rtN(rtN),
    .wrEn(wrEn), .rdEn(rdEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .halfN(halfN), .qOe(qOe)
  );

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  // standalone vectors: wr rd rtN | fullN emptyN halfN | wrAddr rdAddr (after the edge)
  localparam logic [9:0] VEC [14] = '{
    10'b101_111_01_00, // R8 first write
    10'b101_111_10_00,
    10'b101_110_11_00, // R9 three words > half
    10'b011_111_11_01, // R4 read
    10'b011_111_11_10,
    10'b110_110_11_00, // R10 retransmit blocks wr/rd, count back to 3
    10'b101_010_00_00, // R3 full, R8 wrap
    10'b101_010_00_00, // R3 write to full ignored
    10'b011_110_00_01,
    10'b111_110_01_10, // R8 write+read keeps count
    10'b011_111_01_11,
    10'b011_111_01_00, // R8 read wrap
    10'b011_101_01_01, // R4 empty
    10'b011_101_01_01  // R4 read on empty ignored
  };

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic fl, input logic xi);
    @(negedge clk);
    rstN = 1'b0; firstLoadN = fl; expInN = xi; idleXi = xi;
    wrReq = 1'b0; rdReq = 1'b0; rtN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic step(input logic w, input logic r, input logic rt, input logic xi);
    @(negedge clk);
    wrReq = w; rdReq = r; rtN = rt; expInN = xi;
    @(posedge clk);
    #2;
    wrReq = 1'b0; rdReq = 1'b0; rtN = 1'b1; expInN = idleXi;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // ---------- standalone mode ----------
    doReset(1'b1, 1'b0);
    chk("R1 emptyN", emptyN, 0);
    chk("R1 fullN", fullN, 1);
    chk("R1 halfN", halfN, 1);
    chk("R1 wrAddr", wrAddr, 0);
    chk("R1 rdAddr", rdAddr, 0);
    chk("R2 qOe standalone", qOe, 1);

    for (int i = 0; i < 14; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7], 1'b0);
      chk($sformatf("R3/R4 fullN vec%0d", i), fullN, VEC[i][6]);
      chk($sformatf("R4 emptyN vec%0d", i), emptyN, VEC[i][5]);
      chk($sformatf("R9 halfN vec%0d", i), halfN, VEC[i][4]);
      chk($sformatf("R8 wrAddr vec%0d", i), wrAddr, VEC[i][3:2]);
      chk($sformatf("R8/R10 rdAddr vec%0d", i), rdAddr, VEC[i][1:0]);
      chk($sformatf("R2 expOutN vec%0d", i), expOutN, 1);
    end

    // ---------- ring mode, first device ----------
    doReset(1'b0, 1'b1);
    chk("R1 ring qOe first", qOe, 1);
    chk("R1 ring emptyN", emptyN, 0);
    chk("R1 ring expOutN", expOutN, 1);
    step(1, 0, 1, 1); step(1, 0, 1, 1); step(1, 0, 1, 1);
    chk("R9 halfN held high in ring", halfN, 1);
    chk("R5 no pulse before last", expOutN, 1);
    step(1, 0, 1, 1);
    chk("R5 pulse after last write", expOutN, 0);
    chk("R3 fullN", fullN, 0);
    chk("R8 wrAddr wrapped", wrAddr, 0);
    step(0, 0, 1, 1);
    chk("R5 pulse one cycle", expOutN, 1);
    step(0, 1, 1, 1);
    chk("R8 rdAddr", rdAddr, 1);
    @(negedge clk); wrReq = 1'b1; #1;
    chk("R5 write refused after release", wrEn, 0);
    @(posedge clk); #2; wrReq = 1'b0;
    chk("R5 wrAddr unchanged", wrAddr, 0);
    step(0, 0, 0, 1);
    chk("R10 rtN ignored in ring", rdAddr, 1);
    step(0, 1, 1, 1); step(0, 1, 1, 1);
    chk("R6 no pulse before last read", expOutN, 1);
    step(0, 1, 1, 1);
    chk("R6 pulse after last read", expOutN, 0);
    chk("R11 qOe drops", qOe, 0);
    chk("R4 emptyN", emptyN, 0);
    step(0, 0, 1, 1);
    chk("R6 pulse one cycle", expOutN, 1);
    step(0, 0, 1, 0);
    chk("R7 first pulse not read token", qOe, 0);
    step(1, 0, 1, 1);
    chk("R7 write token granted", wrAddr, 1);
    @(negedge clk); rdReq = 1'b1; #1;
    chk("R11 read refused without token", rdEn, 0);
    @(posedge clk); #2; rdReq = 1'b0;
    chk("R4 rdAddr unchanged", rdAddr, 0);
    step(1, 0, 1, 1); step(1, 0, 1, 1);
    chk("R8 wrAddr", wrAddr, 3);
    step(1, 0, 1, 0); // last write and incoming pulse in the same cycle
    chk("R5 pulse with concurrent grant", expOutN, 0);
    chk("R7 concurrent pulse grants read", qOe, 1);
    chk("R3 full", fullN, 0);
    step(1, 0, 1, 1);
    chk("R5 write refused", wrAddr, 0);
    chk("R5 pulse ended", expOutN, 1);
    step(0, 1, 1, 1);
    chk("R7 read works after grant", rdAddr, 1);
    chk("R4 emptyN high", emptyN, 1);

    // ---------- ring mode, other device ----------
    doReset(1'b1, 1'b1);
    chk("R1 idle device qOe", qOe, 0);
    @(negedge clk); wrReq = 1'b1; #1;
    chk("R1 idle device wrEn", wrEn, 0);
    @(posedge clk); #2; wrReq = 1'b0;
    chk("R1 idle device wrAddr", wrAddr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule